// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block models a small fuse-configured logic device. Sixteen logic inputs are spread into thirty-two matrix columns, one true and one inverted copy of each signal. Sixty-four product terms each take the AND of the columns whose fuse is intact. The terms fall into eight groups of eight, and each group drives one output cell. The cell ORs its group, can invert the result, and can present it either straight through or from a flip-flop that captures it on the clock.

The fuse map lives in on-chip flops. A parallel port writes it one fuse per clock: a linear address, one data bit and a write strobe. Two static configuration vectors, one bit per cell each, select registered mode and output inversion. A typical user clears the array with reset, loads all 2048 fuses from a host, sets the cell configuration and then uses the outputs as ordinary logic.

Top module: `sop_logic_array`

## Requirements
- R1: While reset is low the fuse map returns to all ones (every crosspoint open). With no fuse written, each non-registered cell then shows 1 XOR its inversion bit.
- R2: A write with `fuse_we_i` high sets the fuse at `fuse_addr_i` to `fuse_data_i` at the next rising clock edge. Address = term*32 + column. Column 2k is input k true and column 2k+1 is input k inverted. Term t feeds cell t/8.
- R3: Fuse value 0 connects its column into the product term and value 1 disconnects it. A product term is the AND of all its connected columns.
- R4: A term with every fuse at 0 is always 0, because each input meets its own complement. A term with every fuse at 1 is always 1.
- R5: The sum of a cell is the OR of its eight product terms.
- R6: When `cell_inv_i[c]` is 1, cell c's value is the complement of its sum.
- R7: With `cell_reg_i[c]` at 1, `out_o[c]` shows the value (sum XOR inversion) captured at the last rising edge and holds it while the inputs change between edges.
- R8: Reset is asynchronous and active low. It clears every cell flip-flop to 0 at once.
- R9: With `fuse_we_i` low, the address and data inputs have no effect on the fuse map.
- R10: When a fuse write and a registered capture share one edge, the flip-flop captures the value from the map as it was before the write. The new map first shows in the capture at the following edge.
- R11: `cell_reg_i` selects the output source combinationally. A non-registered cell follows the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for fuse writes and registered cells |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_i | input | 16 | Logic inputs to the matrix |
| fuse_we_i | input | 1 | Fuse write strobe |
| fuse_addr_i | input | 11 | Linear fuse address |
| fuse_data_i | input | 1 | Fuse value to write (1 open, 0 connected) |
| cell_reg_i | input | 8 | Per-cell registered-mode select |
| cell_inv_i | input | 8 | Per-cell output inversion |
| out_o | output | 8 | Cell outputs |

## Verification
Two functions can act on the same rising edge: a fuse write that changes a cell's sum, and that cell's flip-flop capturing the sum. The bench places a cell in registered mode with inputs that make one of its terms true. On the capture edge it writes the fuse that kills that term. The output after that edge must still show the old value, and only the edge after must show the new one. A bench-side fuse model reaches the same result, because it applies each write only after it has taken the capture value.

// File: rtl/sop_array_pkg.sv
`timescale 1ns/1ps
package sop_array_pkg;
  localparam int unsigned IN_W_DEF  = 16;
  localparam int unsigned CELLS_DEF = 8;
  localparam int unsigned TPC_DEF   = 8;

  typedef struct packed {
    logic reg_mode;
    logic invert;
  } cell_cfg_t;
endpackage

// File: rtl/sop_fuse_store.sv
`timescale 1ns/1ps
module sop_fuse_store #(
  parameter  int unsigned N_FUSE = 2048,
  localparam int unsigned AW     = $clog2(N_FUSE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              data_i,
  output logic [N_FUSE-1:0] fuse_o
);
  logic [N_FUSE-1:0] fuse_q;

  // blank map: every crosspoint open
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      fuse_q <= '1;
    else if (we_i && (32'(addr_i) < N_FUSE))
      fuse_q[addr_i] <= data_i;
  end

  assign fuse_o = fuse_q;

  // R2
  write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> fuse_o[$past(addr_i)] == $past(data_i));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !we_i |=> $stable(fuse_o));
endmodule

// File: rtl/sop_term.sv
`timescale 1ns/1ps
module sop_term #(
  parameter int unsigned N_COL = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_COL-1:0] cols_i,
  input  logic [N_COL-1:0] fuse_row_i,
  output logic             term_o
);
  // an open fuse (1) forces its column to 1 in the AND
  assign term_o = &(cols_i | fuse_row_i);

  // R4
  dead_term_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fuse_row_i == '0) |-> !term_o);

  // R4
  open_term_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fuse_row_i == '1) |-> term_o);
endmodule

// File: rtl/sop_cell.sv
`timescale 1ns/1ps
module sop_cell
  import sop_array_pkg::*;
#(
  parameter int unsigned N_TERM = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TERM-1:0] terms_i,
  input  cell_cfg_t         cfg_i,
  output logic              out_o
);
  logic sum_w;
  logic val_w;
  logic q_r;

  assign sum_w = |terms_i;
  assign val_w = sum_w ^ cfg_i.invert;

  // flop tracks every cycle so a mode switch shows a fresh capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_r <= 1'b0;
    else         q_r <= val_w;
  end

  assign out_o = cfg_i.reg_mode ? q_r : val_w;

  // R7
  reg_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && cfg_i.reg_mode |-> out_o == $past(val_w));
endmodule

// File: rtl/sop_logic_array.sv
`timescale 1ns/1ps
module sop_logic_array
  import sop_array_pkg::*;
#(
  parameter  int unsigned IN_W   = IN_W_DEF,
  parameter  int unsigned CELLS  = CELLS_DEF,
  parameter  int unsigned TPC    = TPC_DEF,
  localparam int unsigned N_COL  = 2 * IN_W,
  localparam int unsigned N_TERM = CELLS * TPC,
  localparam int unsigned N_FUSE = N_TERM * N_COL,
  localparam int unsigned AW     = $clog2(N_FUSE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  in_i,
  input  logic             fuse_we_i,
  input  logic [AW-1:0]    fuse_addr_i,
  input  logic             fuse_data_i,
  input  logic [CELLS-1:0] cell_reg_i,
  input  logic [CELLS-1:0] cell_inv_i,
  output logic [CELLS-1:0] out_o
);
  logic [N_FUSE-1:0] fuse_w;
  logic [N_COL-1:0]  cols_w;
  logic [N_TERM-1:0] terms_w;

  sop_fuse_store #(.N_FUSE(N_FUSE)) u_fuse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (fuse_we_i),
    .addr_i (fuse_addr_i),
    .data_i (fuse_data_i),
    .fuse_o (fuse_w)
  );

  // even column true, odd column complement
  for (genvar k = 0; k < IN_W; k++) begin : g_col
    assign cols_w[2*k]   = in_i[k];
    assign cols_w[2*k+1] = ~in_i[k];
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    sop_term #(.N_COL(N_COL)) u_term (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cols_i     (cols_w),
      .fuse_row_i (fuse_w[t*N_COL +: N_COL]),
      .term_o     (terms_w[t])
    );
  end

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    cell_cfg_t cfg_w;
    assign cfg_w.reg_mode = cell_reg_i[c];
    assign cfg_w.invert   = cell_inv_i[c];

    sop_cell #(.N_TERM(TPC)) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .terms_i (terms_w[c*TPC +: TPC]),
      .cfg_i   (cfg_w),
      .out_o   (out_o[c])
    );
  end

  // R5
  sum_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_reg_i[0] == 1'b0) && (terms_w[TPC-1:0] == '0) |-> out_o[0] == cell_inv_i[0]);
endmodule

// File: tb/sop_logic_array_tb_top.sv
`timescale 1ns/1ps
module sop_logic_array_tb_top;
  localparam int NI = 16;
  localparam int NC = 8;
  localparam int NT = 64;
  localparam int NK = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] in_v;
  logic        we;
  logic [10:0] addr;
  logic        din;
  logic [7:0]  creg;
  logic [7:0]  cinv;
  logic [7:0]  out_w;

  logic [2047:0] fuse_m;
  logic [7:0]    reg_m;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sop_logic_array dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_i(in_v), .fuse_we_i(we),
    .fuse_addr_i(addr), .fuse_data_i(din), .cell_reg_i(creg),
    .cell_inv_i(cinv), .out_o(out_w)
  );

  function automatic logic [7:0] model_comb(input logic [15:0] x, input logic [7:0] inv);
    logic [31:0] col;
    logic [7:0]  o;
    logic        tm;
    for (int k = 0; k < NI; k++) begin
      col[2*k]   = x[k];
      col[2*k+1] = ~x[k];
    end
    o = '0;
    for (int t = 0; t < NT; t++) begin
      tm = 1'b1;
      for (int c = 0; c < NK; c++)
        if (!fuse_m[t*NK+c]) tm = tm & col[c];
      o[t/8] = o[t/8] | tm;
    end
    return o ^ inv;
  endfunction

  function automatic logic [7:0] exp_out();
    return (creg & reg_m) | (~creg & model_comb(in_v, cinv));
  endfunction

  // connect mask per term: 1 = fuse programmed to 0
  function automatic logic [31:0] pat(input int t);
    int c = t / 8;
    int k = t % 8;
    logic [31:0] m = '0;
    if (k == 0) begin
      m[2*c] = 1'b1;
      m[2*(c+8)+1] = 1'b1;
    end else if (k == 1) begin
      m[2*((c+3)%16)] = 1'b1;
      m[2*((c+5)%16)+1] = 1'b1;
      m[2*((c+11)%16)] = 1'b1;
    end else begin
      m[2*k] = 1'b1;
      m[2*k+1] = 1'b1;
    end
    return m;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: out=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    logic [7:0] pre;
    pre = model_comb(in_v, cinv);
    @(posedge clk);
    if (rst_n) begin
      reg_m = pre;
      if (we) fuse_m[addr] = din;
    end else begin
      reg_m = '0;
      fuse_m = '1;
    end
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic d);
    we = 1'b1; addr = 11'(a); din = d;
    tick();
    we = 1'b0;
  endtask

  task automatic prog_term(input int t, input logic [31:0] m);
    for (int c = 0; c < NK; c++) wr(t*NK + c, ~m[c]);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; in_v = '0; we = 1'b0; addr = '0; din = 1'b0;
    creg = 8'hFF; cinv = 8'h00;
    fuse_m = '1; reg_m = '0;
    #2 rst_n = 1'b0;
    @(negedge clk); #1;
    chk("R8 reset clears registered cells", out_w, 8'h00);
    creg = 8'h00; #1;
    chk("R1 blank map drives ones", out_w, 8'hFF);
    @(negedge clk) rst_n = 1'b1;
    tick();

    // R1 blank map is independent of inputs
    for (int i = 0; i < 8; i++) begin
      in_v = 16'(i * 9973); #1;
      chk("R1 blank map", out_w, 8'hFF);
      @(negedge clk);
    end

    for (int t = 0; t < NT; t++) prog_term(t, pat(t));

    // R2 R3 R5 combinational sweep
    for (int i = 0; i < 1024; i++) begin
      in_v = 16'(i * 40503); #1;
      chk("R2 R3 R5 comb sweep", out_w, exp_out());
      @(negedge clk);
    end
    // R5 single input hits only its own cell
    for (int c = 0; c < NC; c++) begin
      in_v = 16'(1 << c); #1;
      chk("R5 single term per cell", out_w, 8'(1 << c));
      @(negedge clk);
    end

    // R6 inversion
    cinv = 8'hA5;
    in_v = '0; #1;
    chk("R6 inverted zero sums", out_w, 8'hA5);
    @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      in_v = 16'(i * 7919 + 3); #1;
      chk("R6 inverted sweep", out_w, exp_out());
      @(negedge clk);
    end

    // R7 registered hold and capture, full and mixed
    cinv = 8'h3C; creg = 8'hFF;
    tick();
    for (int i = 0; i < 384; i++) begin
      if (i == 256) creg = 8'hF0;
      in_v = 16'(i * 25173 + 13849); #1;
      chk("R7 hold between edges", out_w, exp_out());
      tick(); #1;
      chk("R7 capture at edge", out_w, exp_out());
      @(negedge clk);
    end

    // R11 mode select is combinational
    creg = 8'hFF; cinv = 8'h00;
    tick();
    in_v = 16'h5A3C; #1;
    creg = 8'h00; #1;
    chk("R11 switch to comb", out_w, model_comb(in_v, cinv));
    @(negedge clk);

    // R10 write and capture in the same edge
    creg = 8'hFF; in_v = 16'h0001;
    tick(); #1;
    chk("R10 setup", out_w & 8'h01, 8'h01);
    @(negedge clk);
    wr(1, 1'b0); #1;
    chk("R10 capture uses old map", out_w & 8'h01, 8'h01);
    chk("R10 model", out_w, exp_out());
    @(negedge clk);
    tick(); #1;
    chk("R10 new map next edge", out_w & 8'h01, 8'h00);
    @(negedge clk);
    wr(1, 1'b1);

    // R9 strobe low ignores address and data
    creg = 8'h00; in_v = 16'h0001;
    for (int i = 0; i < 40; i++) begin
      we = 1'b0; addr = 11'(1 + 32 * (i % 8)); din = 1'b0;
      tick(); #1;
      chk("R9 ignored write", out_w & 8'h01, 8'h01);
      chk("R9 model", out_w, exp_out());
      @(negedge clk);
    end

    // R4 dead terms then open term in cell 3
    prog_term(24, 32'hFFFF_FFFF);
    prog_term(25, 32'hFFFF_FFFF);
    for (int i = 0; i < 128; i++) begin
      in_v = 16'(i * 31337 + 7); #1;
      chk("R4 all-connected term is 0", out_w & 8'h08, 8'h00);
      @(negedge clk);
    end
    prog_term(24, 32'h0);
    for (int i = 0; i < 64; i++) begin
      in_v = 16'(i * 12345 + 1); #1;
      chk("R4 all-open term is 1", out_w & 8'h08, 8'h08);
      chk("R4 model", out_w, exp_out());
      @(negedge clk);
    end

    // R8 asynchronous reset mid-cycle
    creg = 8'h0F; cinv = 8'h00;
    tick();
    rst_n = 1'b0; #1;
    reg_m = '0; fuse_m = '1;
    chk("R8 async clear with R1 blank map", out_w, 8'hF0);
    tick();
    rst_n = 1'b1;
    tick(); #1;
    chk("R8 after release", out_w, exp_out());

    done = 1;
    summary();
    $finish;
  end
endmodule